// File: doc/BRIEF.md
# Pixel Dual Counter with Selectable Pairing

This block is the digital logic that sits behind the discriminators of a 2x2 group of pixel cells. For each pixel it runs two counters side by side while an acquisition window (the shutter) is open, clocked by a reference time clock. The first counter always measures how long the discriminator stays high (time over threshold, TOT). The second counter measures either the time from the first hit to the end of the window (time of arrival, TOA) or the number of discriminator pulses (photon counting). The TOT value is kept next to the TOA value so that the amplitude-dependent timewalk of TOA can be corrected downstream. Photon counting is meant for equalizing the pixel thresholds.

A super-pixel option merges the four pixels of the group. Their discriminators are ORed, and the matching counters of the four pixels are chained into one counter that is four times deeper. Each counter saturates rather than wrapping. Each pixel also keeps a hit flag that readout uses to skip empty pixels. Opening a new shutter restarts every counter and flag. The discriminator and shutter inputs are taken as already synchronous to the reference clock.

Top module: `pixelDualCounter`

## Requirements
- R1: While the shutter is sampled high, a pixel's TOT counter increments by one in every cycle in which its discriminator is sampled high. The pixels occupy lanes of width CNT_W in the output vectors, pixel 0 in the least significant lane.
- R2: With countMode at 0, the second counter starts in the first cycle in which the discriminator is sampled high after having been sampled low in the previous cycle while the shutter is high. That cycle counts as one, and every following shutter-high cycle adds one. Later rising edges in the same window do not restart it. A discriminator that is already high when the shutter opens starts nothing until it rises again.
- R3: With countMode at 1, the second counter instead increments once for each rising edge of the discriminator, as defined in R2, inside the shutter.
- R4: In normal mode, every counter lane stops at its all-ones value (15 for CNT_W=4) and does not wrap.
- R5: A pixel's hit flag becomes 1 after any cycle in which its discriminator is sampled high inside the shutter. It stays 1 until the next shutter opening.
- R6: In the first cycle in which the shutter is sampled high after being low, all counters and hit flags restart from zero. That cycle's own activity is included, and the outputs read 0 after reset.
- R7: While the shutter is sampled low, no counter or hit flag changes, whatever the discriminators do.
- R8: With superEn at 1, the OR of the four discriminators drives one TOT and one second counter, each 4*CNT_W bits wide, across the full output vectors with pixel 0 least significant. All four hit flags then read the same value.
- R9: In super-pixel mode the chained counters stop at all ones over the full 4*CNT_W bits.
- R10: In normal mode, activity on one pixel leaves the counters and hit flags of the other pixels at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference time clock |
| rstN | input | 1 | Asynchronous reset, active low |
| shutter | input | 1 | Acquisition window, high while open |
| disc | input | 4 | Discriminator outputs, bit i for pixel i |
| countMode | input | 1 | 0: TOT with TOA, 1: TOT with pulse count |
| superEn | input | 1 | 1: merge the four pixels into one deep counter |
| totOut | output | 4*CNT_W | TOT lanes, pixel i at bits i*CNT_W upward |
| secOut | output | 4*CNT_W | Second counter lanes (TOA or pulse count) |
| hitOut | output | 4 | Hit flags, bit i for pixel i |

## Verification
Several rules are checked on every clock by the assertions. Counters are frozen while the shutter is closed. A lane advances by at most one per cycle. A saturated lane stays saturated. Hit flags remain set within a window. The pulse counter moves only on a discriminator rising edge. Super-pixel hit flags stay identical. Only the scenarios can show the absolute values: the TOA start point and the fact that later edges do not restart it, the pre-raised discriminator case, the carry between chained lanes, the deep saturation point, and the isolation between pixels in normal mode.

// File: rtl/pdcPkg.sv
package pdcPkg;
  // a 2x2 group of pixel cells
  localparam int NPIX = 4;

  // strobes from control to datapath, one bit per pixel lane
  typedef struct packed {
    logic            clr;
    logic [NPIX-1:0] totInc;
    logic [NPIX-1:0] secInc;
    logic [NPIX-1:0] hitSet;
  } pdcStrobes_t;
endpackage

// File: rtl/pdcChainCounter.sv
module pdcChainCounter #(
  parameter int W     = 4,
  parameter int NLANE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               superEn,
  input  logic [NLANE-1:0]   inc,
  output logic [NLANE*W-1:0] cntOut
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt  [NLANE];
  logic [W-1:0] base [NLANE];
  logic [NLANE:0] belowFull;

  // belowFull[i]: every lane under i is at its maximum (carry reaches i)
  always_comb begin
    belowFull[0] = 1'b1;
    for (int i = 0; i < NLANE; i++) begin
      belowFull[i+1] = belowFull[i] & (base[i] == MAXV);
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : gLane
    logic bumpNorm;
    logic bumpSup;
    assign base[g]  = clr ? '0 : cnt[g];
    assign bumpNorm = inc[g] && (base[g] != MAXV);
    assign bumpSup  = inc[0] && belowFull[g] && !belowFull[NLANE];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[g] <= '0;
      end else if (superEn ? bumpSup : bumpNorm) begin
        cnt[g] <= base[g] + 1'b1;
      end else begin
        cnt[g] <= base[g];
      end
    end

    assign cntOut[g*W +: W] = cnt[g];
  end
endmodule

// File: rtl/pdcControl.sv
module pdcControl
  import pdcPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            shutter,
  input  logic [NPIX-1:0] disc,
  input  logic            countMode,
  input  logic            superEn,
  output pdcStrobes_t     strobes
);
  logic            shutPrev;
  logic [NPIX-1:0] discPrev;
  logic [NPIX-1:0] toaRun;
  logic            openEv;
  logic [NPIX-1:0] discEff;
  logic [NPIX-1:0] discEffPrev;
  logic [NPIX-1:0] rise;
  logic [NPIX-1:0] toaInc;
  logic [NPIX-1:0] cntInc;

  assign openEv = shutter & ~shutPrev;

  // in super-pixel mode every lane sees the OR of the group
  for (genvar p = 0; p < NPIX; p++) begin : gPix
    assign discEff[p]     = superEn ? |disc     : disc[p];
    assign discEffPrev[p] = superEn ? |discPrev : discPrev[p];
    assign rise[p]        = discEff[p] & ~discEffPrev[p];
    assign toaInc[p]      = shutter & (rise[p] | (toaRun[p] & ~openEv));
    assign cntInc[p]      = shutter & rise[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutPrev <= 1'b0;
      discPrev <= '0;
      toaRun   <= '0;
    end else begin
      shutPrev <= shutter;
      discPrev <= disc;
      if (shutter) begin
        toaRun <= (openEv ? '0 : toaRun) | rise;
      end
    end
  end

  always_comb begin
    strobes.clr    = openEv;
    strobes.totInc = {NPIX{shutter}} & discEff;
    strobes.secInc = countMode ? cntInc : toaInc;
    strobes.hitSet = {NPIX{shutter}} & discEff;
  end
endmodule

// File: rtl/pdcDatapath.sv
module pdcDatapath
  import pdcPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  superEn,
  input  pdcStrobes_t           strobes,
  output logic [NPIX*CNT_W-1:0] totOut,
  output logic [NPIX*CNT_W-1:0] secOut,
  output logic [NPIX-1:0]       hitOut
);
  logic [NPIX-1:0] hitFlag;

  pdcChainCounter #(.W(CNT_W), .NLANE(NPIX)) i_totCnt (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (strobes.clr),
    .superEn (superEn),
    .inc     (strobes.totInc),
    .cntOut  (totOut)
  );

  pdcChainCounter #(.W(CNT_W), .NLANE(NPIX)) i_secCnt (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (strobes.clr),
    .superEn (superEn),
    .inc     (strobes.secInc),
    .cntOut  (secOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitFlag <= '0;
    end else if (strobes.clr) begin
      hitFlag <= strobes.hitSet;
    end else begin
      hitFlag <= hitFlag | strobes.hitSet;
    end
  end

  assign hitOut = hitFlag;
endmodule

// File: rtl/pixelDualCounter.sv
module pixelDualCounter
  import pdcPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  shutter,
  input  logic [NPIX-1:0]       disc,
  input  logic                  countMode,
  input  logic                  superEn,
  output logic [NPIX*CNT_W-1:0] totOut,
  output logic [NPIX*CNT_W-1:0] secOut,
  output logic [NPIX-1:0]       hitOut
);
  pdcStrobes_t strobes;

  pdcControl i_control (
    .clk       (clk),
    .rstN      (rstN),
    .shutter   (shutter),
    .disc      (disc),
    .countMode (countMode),
    .superEn   (superEn),
    .strobes   (strobes)
  );

  pdcDatapath #(.CNT_W(CNT_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .superEn (superEn),
    .strobes (strobes),
    .totOut  (totOut),
    .secOut  (secOut),
    .hitOut  (hitOut)
  );
endmodule

// File: rtl/pdcChecker.sv
module pdcChecker
  import pdcPkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  shutter,
  input logic [NPIX-1:0]       disc,
  input logic                  countMode,
  input logic                  superEn,
  input logic [NPIX*CNT_W-1:0] totOut,
  input logic [NPIX*CNT_W-1:0] secOut,
  input logic [NPIX-1:0]       hitOut
);
  localparam logic [CNT_W-1:0] LANE_MAX = '1;

  // R7: closed shutter freezes every output
  assert_hold_closed_R7: assert property (@(posedge clk) disable iff (!rstN)
    !shutter |=> ($stable(totOut) && $stable(secOut) && $stable(hitOut)));

  // R1: a normal-mode TOT lane moves by at most one per cycle inside a window
  assert_tot_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!superEn && shutter && $past(shutter)) |=>
      ((totOut[CNT_W-1:0] == $past(totOut[CNT_W-1:0])) ||
       (totOut[CNT_W-1:0] == $past(totOut[CNT_W-1:0]) + 1'b1)));

  // R4: a saturated lane stays saturated inside the window
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!superEn && shutter && $past(shutter) && totOut[CNT_W-1:0] == LANE_MAX) |=>
      (totOut[CNT_W-1:0] == LANE_MAX));

  // R5: a set hit flag is kept until a new opening
  assert_hit_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hitOut[0] && !(shutter && !$past(shutter))) |=> hitOut[0]);

  // R3: pulse counter moves only on a discriminator rising edge
  assert_count_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (countMode && !superEn && shutter && $past(shutter) &&
     !(disc[0] && !$past(disc[0]))) |=> $stable(secOut[CNT_W-1:0]));

  // R6: right after an opening a normal lane holds at most one count
  assert_clear_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!superEn && shutter && !$past(shutter)) |=>
      (totOut[CNT_W-1:0] <= 1 && secOut[CNT_W-1:0] <= 1));

  // R8: super-pixel hit flags agree
  assert_super_hits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (superEn && shutter) |=> (hitOut == '0 || hitOut == '1));
endmodule

bind pixelDualCounter pdcChecker #(.CNT_W(CNT_W)) i_pdcChecker (
  .clk       (clk),
  .rstN      (rstN),
  .shutter   (shutter),
  .disc      (disc),
  .countMode (countMode),
  .superEn   (superEn),
  .totOut    (totOut),
  .secOut    (secOut),
  .hitOut    (hitOut)
);

// File: tb/test_pixelDualCounter.sv
module test_pixelDualCounter;
  localparam int CNT_W = 4;
  localparam int NP    = 4;
  localparam int VW    = NP * CNT_W;

  logic          clk = 1'b0;
  logic          rstN;
  logic          shutter;
  logic [NP-1:0] disc;
  logic          countMode;
  logic          superEn;
  logic [VW-1:0] totOut;
  logic [VW-1:0] secOut;
  logic [NP-1:0] hitOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pixelDualCounter #(.CNT_W(CNT_W)) i_pixelDualCounter (
    .clk(clk), .rstN(rstN), .shutter(shutter), .disc(disc),
    .countMode(countMode), .superEn(superEn),
    .totOut(totOut), .secOut(secOut), .hitOut(hitOut)
  );

  // columns: mode, super, pixel, window, discStart, discLen, expTot, expSec, expHit
  localparam int ROWS = 6;
  localparam int tbl [ROWS][9] = '{
    '{0, 0, 0, 10, 2, 3,  3,  8, 1},
    '{0, 0, 1, 20, 1, 18, 15, 15, 1},
    '{1, 0, 2, 10, 3, 4,  4,  1, 1},
    '{0, 0, 3, 8,  0, 8,  8,  8, 1},
    '{0, 0, 0, 6,  0, 0,  0,  0, 0},
    '{0, 0, 2, 8,  6, 5,  2,  2, 1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic sh, input logic [NP-1:0] d);
    shutter = sh;
    disc    = d;
    @(negedge clk);
  endtask

  task automatic setMode(input logic md, input logic sp);
    countMode = md;
    superEn   = sp;
    cyc(1'b0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; shutter = 1'b0; disc = '0; countMode = 1'b0; superEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 reset tot", 32'(totOut), 0);
    check("R6 reset sec", 32'(secOut), 0);
    check("R6 reset hit", 32'(hitOut), 0);

    // table walk: R1 R2 R3 R4 R5 R10
    for (int r = 0; r < ROWS; r++) begin
      setMode(tbl[r][0][0], tbl[r][1][0]);
      for (int c = 0; c < tbl[r][3] + 2; c++) begin
        logic [NP-1:0] d;
        d = '0;
        if (tbl[r][5] > 0 && c >= tbl[r][4] && c < tbl[r][4] + tbl[r][5]) d[tbl[r][2]] = 1'b1;
        cyc(c < tbl[r][3], d);
      end
      check($sformatf("R1 R4 R10 row %0d tot", r), 32'(totOut),
            32'(tbl[r][6]) << (tbl[r][2] * CNT_W));
      check($sformatf("R2 R3 R4 R10 row %0d sec", r), 32'(secOut),
            32'(tbl[r][7]) << (tbl[r][2] * CNT_W));
      check($sformatf("R5 R10 row %0d hit", r), 32'(hitOut),
            32'(tbl[r][8]) << tbl[r][2]);
    end

    // R2: second rising edge does not restart TOA
    setMode(1'b0, 1'b0);
    for (int c = 0; c < 14; c++)
      cyc(c < 12, ((c >= 2 && c <= 3) || (c >= 7 && c <= 8)) ? 4'b0001 : 4'b0000);
    check("R2 two pulses tot", 32'(totOut), 4);
    check("R2 two pulses toa from first edge", 32'(secOut), 10);

    // R2: discriminator already high at opening starts no TOA
    setMode(1'b0, 1'b0);
    cyc(1'b0, 4'b0010);
    for (int c = 0; c < 12; c++) cyc(c < 10, (c <= 4) ? 4'b0010 : 4'b0000);
    check("R2 prehigh tot", 32'(totOut), 32'(5) << CNT_W);
    check("R2 prehigh toa", 32'(secOut), 0);
    check("R5 prehigh hit", 32'(hitOut), 2);

    // R3: three pulses counted
    setMode(1'b1, 1'b0);
    for (int c = 0; c < 12; c++)
      cyc(c < 10, (c == 1 || c == 4 || c == 7) ? 4'b0001 : 4'b0000);
    check("R3 count tot", 32'(totOut), 3);
    check("R3 count pulses", 32'(secOut), 3);

    // R7: activity with shutter closed is ignored
    for (int c = 0; c < 6; c++) cyc(1'b0, c[0] ? 4'b1111 : 4'b0000);
    check("R7 closed tot", 32'(totOut), 3);
    check("R7 closed sec", 32'(secOut), 3);
    check("R7 closed hit", 32'(hitOut), 1);

    // R6: new window without activity clears everything
    for (int c = 0; c < 6; c++) cyc(c < 4, 4'b0000);
    check("R6 clear tot", 32'(totOut), 0);
    check("R6 clear sec", 32'(secOut), 0);
    check("R6 clear hit", 32'(hitOut), 0);

    // R8: super-pixel TOT/TOA with carry into lane 1
    setMode(1'b0, 1'b1);
    for (int c = 0; c < 32; c++) cyc(c < 30, (c >= 5 && c < 25) ? 4'b1000 : 4'b0000);
    check("R8 super tot", 32'(totOut), 32'h14);
    check("R8 super toa", 32'(secOut), 32'h19);
    check("R8 super hit", 32'(hitOut), 4'hF);

    // R8: separate pulses on two pixels are two edges of the OR
    setMode(1'b1, 1'b1);
    for (int c = 0; c < 12; c++)
      cyc(c < 10, (c == 2 || c == 3) ? 4'b0001 : (c == 6 || c == 7) ? 4'b0010 : 4'b0000);
    check("R8 super separate tot", 32'(totOut), 4);
    check("R8 super separate count", 32'(secOut), 2);

    // R8: overlapping pulses merge into one edge
    setMode(1'b1, 1'b1);
    for (int c = 0; c < 12; c++) begin
      logic [NP-1:0] d;
      d = '0;
      if (c >= 2 && c <= 5) d[0] = 1'b1;
      if (c >= 4 && c <= 7) d[1] = 1'b1;
      cyc(c < 10, d);
    end
    check("R8 super overlap tot", 32'(totOut), 6);
    check("R8 super overlap count", 32'(secOut), 1);

    // R9: deep saturation of the chained counters
    setMode(1'b0, 1'b1);
    for (int c = 0; c < 65542; c++) cyc(c < 65540, (c < 65540) ? 4'b0100 : 4'b0000);
    check("R9 deep sat tot", 32'(totOut), 32'hFFFF);
    check("R9 deep sat toa", 32'(secOut), 32'hFFFF);
    check("R9 deep sat hit", 32'(hitOut), 4'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule